// File: doc/BRIEF.md
# Timer Output Compare Channel with PWM

This block turns a free-running timer count into one output pin. In the single-shot modes it drives the pin high or low on the first match against a primary compare value. In the toggle mode it inverts the pin on every match. In the PWM mode it produces a pulse that starts on each period and ends on a duty compare. The duty value is double buffered. Software writes a staging register, and the block copies that register into the working compare register only when the timer reports a period match. Every acted-on match also raises a one-cycle event pulse that can serve as an interrupt request.

Two transitions need care. The first is a period with zero duty. It must show no high pulse at all, and the next nonzero duty must start cleanly at the following period. The second is enabling a mode that drives the pin low later while the pin is already high from an earlier port write. The block then takes over the level already on the pin instead of starting from low. While the channel is off, the pin shows a general-purpose port level, and the compare state is held cleared.

The timer is external. It counts 0 to N-1 and asserts `period_match` during its last count, N-1.

Top module: `oc_pwm_channel`

## Requirements
- R1: After reset, with mode 0 and `port_level` low, `pin_out` is low and `cmp_event` is low.
- R2: Mode codes 0, 5, 6 and 7 are the off state. In the off state the compare level is held low, the single-shot flag is cleared, `pin_out` equals `port_level`, and no event is raised.
- R3: Mode 1 drives the pin high in the cycle after the first cycle where `timer_val` equals `cmp_val`. Later matches have no effect until the channel passes through the off state.
- R4: Mode 2 drives the pin low in the cycle after the first match. When mode 2 is entered from off while `port_level` is high, the pin stays high in every cycle up to that match, including the enable cycle.
- R5: Mode 3 inverts the pin in the cycle after each match, starting from the level that was on the pin when the mode was entered.
- R6: In mode 4 (PWM) with an active duty D, the pin is high for timer counts 0 to D-1 and low for the rest of the period. The rise follows the cycle with `period_match`.
- R7: In PWM mode, a period whose active duty is 0 shows no high cycle at all.
- R8: After a zero-duty period, a nonzero duty staged before the next period match is fully applied in the following period. Its rise and its fall both take place.
- R9: In PWM mode, a duty greater than or equal to the timer period N keeps the pin high for every count of the period.
- R10: A duty write reaches the active compare only at a period match. A write in the same cycle as the period match is applied at the next one.
- R11: `cmp_event` is a one-cycle pulse, aligned with the output change it reports. It is raised for a primary match acted on in modes 1 to 3 and for a duty match in PWM mode. It is not raised when the period start overrides a duty match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| timer_val | input | TMR_W | Current count of the external timer |
| period_match | input | 1 | High during the last count of a timer period |
| cmp_val | input | TMR_W | Primary compare value for modes 1 to 3 |
| duty_wr_en | input | 1 | Write strobe for the staged duty register |
| duty_wr_data | input | TMR_W | Duty value to stage |
| mode | input | 3 | Channel mode code (0 off, 1 set high, 2 set low, 3 toggle, 4 PWM) |
| port_level | input | 1 | General-purpose level shown while off and taken over on enable |
| pin_out | output | 1 | Output pin |
| cmp_event | output | 1 | One-cycle compare event |

## Verification
The bench drives the zero-duty case and then a nonzero duty. A design that rises on the period start without looking at the new duty shows a one-cycle glitch. A design that rearms too late drops the next pulse entirely. The bench enables the drive-low and toggle modes with the pin already high from the port level. A design that resets the level to low on enable shows a one-cycle dip before the match. Full and over-range duty values are run to catch a fall that collides with the period start. A duty write landing on the period-match cycle exposes a buffer that copies the new value one period too early.

// File: rtl/oc_pkg.sv
// Shared definitions for the output compare channel.
// Assumes a 3-bit mode code; codes above the PWM code are treated as off.
package oc_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        OCM_OFF    = 3'd0,
        OCM_SET_HI = 3'd1,
        OCM_SET_LO = 3'd2,
        OCM_TOGGLE = 3'd3,
        OCM_PWM    = 3'd4
    } ocm_e;

    // True when the code selects one of the running modes.
    function automatic logic ocm_running(input logic [MODE_W-1:0] m);
        return (m >= 3'd1) && (m <= 3'd4);
    endfunction

endpackage

// File: rtl/oc_duty_buf.sv
// Double-buffered duty register.
// Software writes land in the staging register; the active register is
// loaded from staging only on the period-match pulse, using the value held
// before any write in the same cycle.
module oc_duty_buf #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TMR_W-1:0] wr_data,
    input  logic             period_match,
    output logic [TMR_W-1:0] duty_stage,
    output logic [TMR_W-1:0] duty_active
);

    // Staging register: capture software writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            duty_stage <= '0;
        else if (wr_en)
            duty_stage <= wr_data;
    end

    // Active register: transfer from staging at each period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            duty_active <= '0;
        else if (period_match)
            duty_active <= duty_stage;
    end

endmodule

// File: rtl/oc_match.sv
// Comparators for the primary compare and the PWM duty compare.
// The duty hit fires on the count before the duty value, so the registered
// output falls exactly when the timer reaches the duty value.
// A zero duty never hits.
module oc_match #(
    parameter int TMR_W = 16
) (
    input  logic [TMR_W-1:0] timer_val,
    input  logic [TMR_W-1:0] cmp_val,
    input  logic [TMR_W-1:0] duty_active,
    output logic             hit_pri,
    output logic             hit_duty
);

    localparam int EXT_W = TMR_W + 1;

    logic [EXT_W-1:0] next_count;
    logic [EXT_W-1:0] duty_ext;

    // Widen by one bit so the increment cannot wrap.
    always_comb begin
        next_count = {1'b0, timer_val} + EXT_W'(1);
        duty_ext   = {1'b0, duty_active};
    end

    // Compare results.
    always_comb begin
        hit_pri  = (timer_val == cmp_val);
        hit_duty = (duty_active != '0) && (next_count == duty_ext);
    end

endmodule

// File: rtl/oc_level_ctl.sv
// Output level control for all modes.
// On the first cycle out of the off state, the level already shown on the
// pin (the port level) is the base for the next state, so enabling never
// forces the pin low before a match. In PWM mode the period start wins over
// a duty hit in the same cycle.
module oc_level_ctl
    import oc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              port_level,
    input  logic              period_match,
    input  logic              hit_pri,
    input  logic              hit_duty,
    input  logic              stage_nonzero,
    output logic              pin_out,
    output logic              cmp_event
);

    logic oc_q;
    logic fired_q;
    logic was_off_q;
    logic run_now;
    logic base_lvl;
    logic oc_d;
    logic fired_d;
    logic evt_d;

    // Decode whether the channel runs this cycle.
    always_comb begin
        run_now  = ocm_running(mode);
        base_lvl = was_off_q ? port_level : oc_q;
    end

    // Next level, single-shot flag and event for the current mode.
    always_comb begin
        oc_d    = base_lvl;
        fired_d = fired_q;
        evt_d   = 1'b0;
        if (!run_now) begin
            oc_d    = 1'b0;
            fired_d = 1'b0;
        end else begin
            unique case (ocm_e'(mode))
                OCM_SET_HI: if (hit_pri && !fired_q) begin
                    oc_d    = 1'b1;
                    fired_d = 1'b1;
                    evt_d   = 1'b1;
                end
                OCM_SET_LO: if (hit_pri && !fired_q) begin
                    oc_d    = 1'b0;
                    fired_d = 1'b1;
                    evt_d   = 1'b1;
                end
                OCM_TOGGLE: if (hit_pri) begin
                    oc_d  = ~base_lvl;
                    evt_d = 1'b1;
                end
                OCM_PWM: begin
                    if (period_match) begin
                        oc_d = stage_nonzero;
                    end else if (hit_duty) begin
                        oc_d  = 1'b0;
                        evt_d = 1'b1;
                    end
                end
                default: oc_d = 1'b0;
            endcase
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oc_q      <= 1'b0;
            fired_q   <= 1'b0;
            was_off_q <= 1'b1;
            cmp_event <= 1'b0;
        end else begin
            oc_q      <= oc_d;
            fired_q   <= fired_d;
            was_off_q <= !run_now;
            cmp_event <= evt_d;
        end
    end

    // Pin mux: port level while off or on the takeover cycle.
    always_comb begin
        pin_out = (!run_now || was_off_q) ? port_level : oc_q;
    end

endmodule

// File: rtl/oc_pwm_channel.sv
// Top of the output compare channel.
// Assumes an external timer counting 0..N-1 with period_match high on N-1.
module oc_pwm_channel
    import oc_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMR_W-1:0]  timer_val,
    input  logic              period_match,
    input  logic [TMR_W-1:0]  cmp_val,
    input  logic              duty_wr_en,
    input  logic [TMR_W-1:0]  duty_wr_data,
    input  logic [MODE_W-1:0] mode,
    input  logic              port_level,
    output logic              pin_out,
    output logic              cmp_event
);

    logic [TMR_W-1:0] duty_stage;
    logic [TMR_W-1:0] duty_active;
    logic             hit_pri;
    logic             hit_duty;
    logic             stage_nonzero;

    // Staging-register status for the period start.
    always_comb stage_nonzero = (duty_stage != '0);

    oc_duty_buf #(.TMR_W(TMR_W)) u_duty (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (duty_wr_en),
        .wr_data      (duty_wr_data),
        .period_match (period_match),
        .duty_stage   (duty_stage),
        .duty_active  (duty_active)
    );

    oc_match #(.TMR_W(TMR_W)) u_match (
        .timer_val   (timer_val),
        .cmp_val     (cmp_val),
        .duty_active (duty_active),
        .hit_pri     (hit_pri),
        .hit_duty    (hit_duty)
    );

    oc_level_ctl u_level (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode          (mode),
        .port_level    (port_level),
        .period_match  (period_match),
        .hit_pri       (hit_pri),
        .hit_duty      (hit_duty),
        .stage_nonzero (stage_nonzero),
        .pin_out       (pin_out),
        .cmp_event     (cmp_event)
    );

endmodule

// File: rtl/oc_pwm_channel_chk.sv
// Property checker for the output compare channel, bound to the top.
module oc_pwm_channel_chk #(
    parameter int TMR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             period_match,
    input logic [2:0]       mode,
    input logic             pin_out,
    input logic             cmp_event,
    input logic             hit_pri,
    input logic [TMR_W-1:0] duty_stage
);

    assert_off_no_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 || mode > 3'd4) |=> !cmp_event);

    assert_hi_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 3'd1 && mode == 3'd1 && $past(pin_out)) |-> pin_out);

    assert_lo_no_dip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 3'd2 && mode == 3'd2 && $past(pin_out) && !$past(hit_pri)) |-> pin_out);

    assert_pwm_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4 && period_match && duty_stage != '0) |=> (pin_out || mode != 3'd4));

    assert_zero_duty_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4 && period_match && duty_stage == '0) |=> (!pin_out || mode != 3'd4));

    assert_toggle_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 3'd3 && mode == 3'd3 && cmp_event) |-> (pin_out != $past(pin_out)));

endmodule

bind oc_pwm_channel oc_pwm_channel_chk #(.TMR_W(TMR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_match (period_match),
    .mode         (mode),
    .pin_out      (pin_out),
    .cmp_event    (cmp_event),
    .hit_pri      (hit_pri),
    .duty_stage   (duty_stage)
);

// File: tb/oc_pwm_channel_bench.sv
module oc_pwm_channel_bench;

    localparam int W   = 16;
    localparam int PER = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] tmr = '0;
    logic         pm;
    logic [W-1:0] cmp = '0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [2:0]   mode = 3'd0;
    logic         port_lvl = 1'b0;
    logic         pin_out;
    logic         cmp_event;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    string req = "R1";

    // Reference model state
    int m_oc = 0, m_fired = 0, m_wasoff = 1, m_evt = 0, m_stage = 0, m_act = 0;

    always #4 clk = ~clk;
    assign pm = (tmr == W'(PER - 1));

    oc_pwm_channel #(.TMR_W(W)) u_oc_pwm_channel (
        .clk(clk), .rst_n(rst_n), .timer_val(tmr), .period_match(pm),
        .cmp_val(cmp), .duty_wr_en(wr_en), .duty_wr_data(wr_data),
        .mode(mode), .port_level(port_lvl), .pin_out(pin_out), .cmp_event(cmp_event)
    );

    function automatic bit is_run(input logic [2:0] m);
        return m >= 3'd1 && m <= 3'd4;
    endfunction

    // Timer and behavioural reference, advanced on each rising edge.
    always @(posedge clk) begin
        int nx_oc, nx_f, nx_e, base;
        if (!rst_n) begin
            m_oc = 0; m_fired = 0; m_wasoff = 1; m_evt = 0; m_stage = 0; m_act = 0;
            tmr <= '0;
        end else begin
            base = m_wasoff ? int'(port_lvl) : m_oc;
            nx_oc = base; nx_f = m_fired; nx_e = 0;
            if (!is_run(mode)) begin
                nx_oc = 0; nx_f = 0;
            end else if (mode == 3'd1 || mode == 3'd2) begin
                if (tmr == cmp && m_fired == 0) begin
                    nx_oc = (mode == 3'd1) ? 1 : 0; nx_f = 1; nx_e = 1;
                end
            end else if (mode == 3'd3) begin
                if (tmr == cmp) begin nx_oc = 1 - base; nx_e = 1; end
            end else begin
                if (pm) nx_oc = (m_stage != 0) ? 1 : 0;
                else if (m_act != 0 && int'(tmr) + 1 == m_act) begin nx_oc = 0; nx_e = 1; end
            end
            m_oc = nx_oc; m_fired = nx_f; m_evt = nx_e;
            m_wasoff = is_run(mode) ? 0 : 1;
            if (pm) m_act = m_stage;
            if (wr_en) m_stage = int'(wr_data);
            tmr <= pm ? '0 : tmr + 1'b1;
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        int ep;
        if (rst_n && !finished) begin
            ep = (!is_run(mode) || m_wasoff != 0) ? int'(port_lvl) : m_oc;
            checks++;
            if (int'(pin_out) != ep || int'(cmp_event) != m_evt) begin
                fails++;
                $display("FAIL %s model: pin=%0d evt=%0d expected pin=%0d evt=%0d at t=%0t",
                         req, pin_out, cmp_event, ep, m_evt, $time);
            end
        end
    end

    task automatic check(input string r, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(posedge clk); #1 mode = m;
    endtask

    task automatic run(input int n, output int ev, output int hi);
        ev = 0; hi = 0;
        repeat (n) begin
            @(negedge clk);
            ev += int'(cmp_event);
            hi += int'(pin_out);
        end
    endtask

    task automatic wait_count(input int c);
        do @(negedge clk); while (int'(tmr) != c);
    endtask

    task automatic write_duty(input int v);
        wait_count(2);
        @(posedge clk); #1 wr_en = 1'b1; wr_data = W'(v);
        @(posedge clk); #1 wr_en = 1'b0;
    endtask

    // Measure one full period starting at count 0.
    task automatic measure(output int ev, output int hi);
        wait_count(PER - 1);
        run(PER, ev, hi);
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int ev, hi, lowb4;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 pin after reset", int'(pin_out), 0);
        check("R1 event after reset", int'(cmp_event), 0);

        // R2: off codes show port level, no events
        req = "R2";
        #1 port_lvl = 1'b1;
        set_mode(3'd5);
        run(PER, ev, hi);
        check("R2 events in code 5", ev, 0);
        check("R2 pin follows port", hi, PER);
        set_mode(3'd0);
        #1 port_lvl = 1'b0;

        // R3: single-shot high
        req = "R3";
        cmp = W'(4);
        set_mode(3'd1);
        run(2 * PER, ev, hi);
        check("R3 single event", ev, 1);
        check("R3 pin held high", int'(pin_out), 1);

        // R4: drive low from an already high pin
        req = "R4";
        set_mode(3'd0);
        #1 port_lvl = 1'b1;
        cmp = W'(6);
        wait_count(0);
        set_mode(3'd2);
        @(negedge clk);
        check("R4 pin on enable cycle", int'(pin_out), 1);
        lowb4 = 0;
        while (!cmp_event) begin
            lowb4 += int'(!pin_out);
            @(negedge clk);
        end
        check("R4 low cycles before match", lowb4, 0);
        check("R4 pin low after match", int'(pin_out), 0);
        #1 port_lvl = 1'b0;

        // R5: toggle starting from a high pin
        req = "R5";
        set_mode(3'd0);
        #1 port_lvl = 1'b1;
        cmp = W'(3);
        wait_count(5);
        set_mode(3'd3);
        run(3 * PER, ev, hi);
        check("R5 toggle events", ev, 3);
        check("R5 final level", int'(pin_out), 0);
        set_mode(3'd0);
        #1 port_lvl = 1'b0;

        // R6: PWM duty 4
        req = "R6";
        write_duty(4);
        set_mode(3'd4);
        measure(ev, hi);
        measure(ev, hi);
        check("R6 high counts duty 4", hi, 4);
        check("R11 one event per period", ev, 1);

        // R7: zero duty
        req = "R7";
        write_duty(0);
        measure(ev, hi);
        measure(ev, hi);
        check("R7 zero duty high counts", hi, 0);
        check("R7 zero duty events", ev, 0);

        // R8: recover to nonzero duty
        req = "R8";
        write_duty(3);
        measure(ev, hi);
        measure(ev, hi);
        check("R8 duty 3 after zero", hi, 3);
        check("R8 fall event present", ev, 1);

        // R9: full and over-range duty
        req = "R9";
        write_duty(PER);
        measure(ev, hi);
        measure(ev, hi);
        check("R9 duty equal period", hi, PER);
        check("R11 no event on overridden fall", ev, 0);
        write_duty(PER + 2);
        measure(ev, hi);
        measure(ev, hi);
        check("R9 duty above period", hi, PER);

        // R10: write coincident with period match takes one period longer
        req = "R10";
        write_duty(2);
        measure(ev, hi);
        measure(ev, hi);
        wait_count(PER - 2);
        @(posedge clk); #1 wr_en = 1'b1; wr_data = W'(6);
        @(posedge clk); #1 wr_en = 1'b0;
        run(PER, ev, hi);
        check("R10 old duty kept", hi, 2);
        measure(ev, hi);
        check("R10 new duty applied", hi, 6);

        // R2: returning to off clears level
        req = "R2";
        set_mode(3'd0);
        @(negedge clk);
        check("R2 off pin with port low", int'(pin_out), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule